// File: doc/BRIEF.md
# Hibernate Wake Source Controller

This block decides when a sleeping system must come back up, and records why. While the system sits in its low-power state, it watches eight general-purpose input pins, a UART receive line and a wake pulse from an external real-time counter. When an armed source fires, it raises a one-cycle wake request, leaves the low-power state and latches a status word. The status word holds a one-hot code for the winning source and a flag that tells a restart from hibernate apart from a cold power-up.

Software sets the block up through a small register port. Each pin has a two-bit trigger mode, which picks a level or an edge of either polarity. A pin enable register and a UART enable register arm sources. Each bit written as 1 is kept in an internal armed flop, but the register itself always reads back as zero. Every armed bit clears when a wake is taken, so software must re-arm before each hibernate. The status stays latched until the next hibernate entry, which clears it.

Register addresses on `regAddr`: 0 is the pin enable (write-1-to-arm, reads 0), 1 is the trigger-mode configuration (read/write), 2 is the UART enable (bit 0, write-1-to-arm, reads 0), 3 is the status (read-only).

Top module: `hib_wake_ctrl`

## Requirements
- R1: After reset the block is awake, `wakeReq` is 0, the status reads 0 (cold start: code 0000, flag 0) and nothing is armed.
- R2: Writing 1s to the pin enable (address 0) or to bit 0 of the UART enable (address 2) arms those sources. Both addresses always read back 0.
- R3: Pin n takes its trigger mode from configuration bits [2n+1:2n]. The modes are 00 = input low, 01 = input high, 10 = falling edge, 11 = rising edge.
- R4: Only pins whose armed bit is set can cause a wake. Activity on unarmed pins has no effect.
- R5: An armed UART source wakes the system on a falling edge of `uartRx`.
- R6: A `rtcWake` pulse wakes the system from the low-power state with no arming needed, and the wake is taken on the first clock edge that samples the pulse.
- R7: Status bits [4:1] hold the source code: 0100 for a pin, 0010 for the real-time counter, 0001 for UART. Status bit 0 is 1 after a wake from hibernate.
- R8: When several sources fire in the same cycle, the real-time counter wins over the pins, and the pins win over UART.
- R9: A taken wake gives a single-cycle `wakeReq`, leaves the low-power state and clears every armed bit.
- R10: While awake, no source causes a wake. Armed bits are kept, so an armed level condition that is still active wakes the system right after the next hibernate entry.
- R11: The status holds its value until a hibernate entry (`hibEnter` while awake), which clears it to 0.
- R12: Pin and UART inputs pass through a two-flop synchronizer. A change applied between clock edges shows on `wakeReq` after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset (cold power-up) |
| hibEnter | input | 1 | Pulse that enters the low-power state |
| rtcWake | input | 1 | Wake pulse from the real-time counter, synchronous to clk |
| gpioIn | input | 8 | Asynchronous wake-capable pins |
| uartRx | input | 1 | Asynchronous UART receive line, idle high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr (combinational) |
| wakeReq | output | 1 | One-cycle wake request |

## Verification
On every cycle, the assertions check that the wake request is a single-cycle pulse and never fires while awake. They also check that a wake clears all armed bits, that the status code is one-hot with the hibernate flag set alongside it, that the status holds between events and clears on entry, and that the real-time counter and the pins win their priority contests. Some behaviours need the bench's scenarios instead: the exact decode of each trigger mode on every pin, the three-edge synchronizer latency, the zero readback of the enables, the way unarmed pins are ignored, and whether arming survives a stretch of awake time. The bench sweeps all eight pins through all four modes.

// File: rtl/hib_wake_pkg.sv
`timescale 1ns/1ps
package hib_wake_pkg;

  localparam int SRC_W = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 4'b0000,
    SRC_UART = 4'b0001,
    SRC_RTC  = 4'b0010,
    SRC_GPIO = 4'b0100
  } wakeSrcE;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trigModeE;

  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } pwrStateE;

  localparam logic [1:0] ADDR_GPIO_EN  = 2'd0;
  localparam logic [1:0] ADDR_TRIG_CFG = 2'd1;
  localparam logic [1:0] ADDR_UART_EN  = 2'd2;
  localparam logic [1:0] ADDR_STATUS   = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic    takeWake;
    wakeSrcE src;
    logic    clearStatus;
  } ctrlStrobeT;

endpackage

// File: rtl/hib_wake_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer followed by a history flop for edge detection.
module hib_wake_sync #(
  parameter int   WIDTH   = 8,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] curOut,
  output logic [WIDTH-1:0] prevOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta, stable, hist;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        meta   <= RST_VAL;
        stable <= RST_VAL;
        hist   <= RST_VAL;
      end else begin
        meta   <= rawIn[b];
        stable <= meta;
        hist   <= stable;
      end
    end
    assign curOut[b]  = stable;
    assign prevOut[b] = hist;
  end

endmodule

// File: rtl/hib_wake_dp.sv
`timescale 1ns/1ps
// Datapath: arming registers, trigger configuration, match logic, status.
module hib_wake_dp
  import hib_wake_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] gpioCur,
  input  logic [NUM_PINS-1:0] gpioPrev,
  input  logic                uartCur,
  input  logic                uartPrev,
  input  ctrlStrobeT          strobe,
  output logic                gpioHit,
  output logic                uartHit,
  output logic [SRC_W:0]      statusOut
);

  localparam int CFG_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] armedGpio;
  logic                armedUart;
  logic [CFG_W-1:0]    trigCfg;
  logic [SRC_W:0]      statusReg;
  logic [NUM_PINS-1:0] pinMatch;

  // per-pin trigger decode
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    trigModeE pinMode;
    assign pinMode = trigModeE'(trigCfg[2*n +: 2]);
    always_comb begin
      unique case (pinMode)
        TRIG_LOW:  pinMatch[n] = ~gpioCur[n];
        TRIG_HIGH: pinMatch[n] = gpioCur[n];
        TRIG_FALL: pinMatch[n] = gpioPrev[n] & ~gpioCur[n];
        TRIG_RISE: pinMatch[n] = ~gpioPrev[n] & gpioCur[n];
        default:   pinMatch[n] = 1'b0;
      endcase
    end
  end

  assign gpioHit = |(pinMatch & armedGpio);
  assign uartHit = armedUart & uartPrev & ~uartCur;

  // arming: write-1-to-set, cleared by a taken wake (clear wins)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedGpio <= '0;
      armedUart <= 1'b0;
    end else if (strobe.takeWake) begin
      armedGpio <= '0;
      armedUart <= 1'b0;
    end else if (wrEn) begin
      if (addr == ADDR_GPIO_EN) armedGpio <= armedGpio | wrData[NUM_PINS-1:0];
      if (addr == ADDR_UART_EN) armedUart <= armedUart | wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                   trigCfg <= '0;
    else if (wrEn && addr == ADDR_TRIG_CFG)      trigCfg <= wrData[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   statusReg <= '0;
    else if (strobe.takeWake)    statusReg <= {strobe.src, 1'b1};
    else if (strobe.clearStatus) statusReg <= '0;
  end

  always_comb begin
    unique case (addr)
      ADDR_TRIG_CFG: rdData = DATA_W'(trigCfg);
      ADDR_STATUS:   rdData = DATA_W'(statusReg);
      default:       rdData = '0;
    endcase
  end

  assign statusOut = statusReg;

  // R7: source code one-hot and accompanied by the hibernate flag
  p_src_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(statusReg[SRC_W:1]));
  p_flag_with_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[SRC_W:1] != '0) |-> statusReg[0]);
  // R9: taking a wake disarms everything
  p_disarm_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeWake |=> (armedGpio == '0) && !armedUart);
  // R11: status cleared on entry, held otherwise
  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearStatus && !strobe.takeWake) |=> (statusReg == '0));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearStatus && !strobe.takeWake) |=> $stable(statusReg));

endmodule

// File: rtl/hib_wake_fsm.sv
`timescale 1ns/1ps
// Control: power state and source arbitration.
module hib_wake_fsm
  import hib_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hibEnter,
  input  logic       rtcWake,
  input  logic       gpioHit,
  input  logic       uartHit,
  output ctrlStrobeT strobe,
  output logic       lowPower,
  output logic       wakeReq
);

  pwrStateE state;
  logic     anyHit;

  assign anyHit = rtcWake | gpioHit | uartHit;

  always_comb begin
    strobe             = '0;
    strobe.takeWake    = (state == ST_ASLEEP) && anyHit;
    strobe.clearStatus = (state == ST_AWAKE) && hibEnter;
    if (rtcWake)      strobe.src = SRC_RTC;
    else if (gpioHit) strobe.src = SRC_GPIO;
    else if (uartHit) strobe.src = SRC_UART;
    else              strobe.src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_AWAKE;
      wakeReq <= 1'b0;
    end else begin
      wakeReq <= strobe.takeWake;
      if (strobe.clearStatus)   state <= ST_ASLEEP;
      else if (strobe.takeWake) state <= ST_AWAKE;
    end
  end

  assign lowPower = (state == ST_ASLEEP);

  // R9: request lasts one cycle
  p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq);
  // R10: no wake from the awake state
  p_awake_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_AWAKE) |=> !wakeReq);
  // R6: RTC pulse always taken while asleep
  p_rtc_taken_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ASLEEP) && rtcWake) |=> wakeReq);

endmodule

// File: rtl/hib_wake_ctrl.sv
`timescale 1ns/1ps
module hib_wake_ctrl
  import hib_wake_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hibEnter,
  input  logic                rtcWake,
  input  logic [NUM_PINS-1:0] gpioIn,
  input  logic                uartRx,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                wakeReq
);

  logic [NUM_PINS-1:0] gpioCur, gpioPrev;
  logic                uartCur, uartPrev;
  logic                gpioHit, uartHit, lowPower;
  logic [SRC_W:0]      statusOut;
  ctrlStrobeT          strobe;

  hib_wake_sync #(.WIDTH(NUM_PINS), .RST_VAL(1'b0)) u_gpio_sync (
    .clk(clk), .rstN(rstN), .rawIn(gpioIn), .curOut(gpioCur), .prevOut(gpioPrev));

  hib_wake_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_uart_sync (
    .clk(clk), .rstN(rstN), .rawIn(uartRx), .curOut(uartCur), .prevOut(uartPrev));

  hib_wake_fsm u_fsm (
    .clk(clk), .rstN(rstN), .hibEnter(hibEnter), .rtcWake(rtcWake),
    .gpioHit(gpioHit), .uartHit(uartHit), .strobe(strobe),
    .lowPower(lowPower), .wakeReq(wakeReq));

  hib_wake_dp #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .rdData(regRdData), .gpioCur(gpioCur), .gpioPrev(gpioPrev),
    .uartCur(uartCur), .uartPrev(uartPrev), .strobe(strobe),
    .gpioHit(gpioHit), .uartHit(uartHit), .statusOut(statusOut));

  // R8: priority of the recorded source
  p_rtc_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lowPower && rtcWake) |=> (statusOut[SRC_W:1] == 4'b0010));
  p_gpio_over_uart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lowPower && !rtcWake && gpioHit) |=> (statusOut[SRC_W:1] == 4'b0100));

endmodule

// File: tb/hib_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module hib_wake_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hibEnter = 1'b0;
  logic        rtcWake = 1'b0;
  logic [7:0]  gpioIn = 8'h00;
  logic        uartRx = 1'b1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        wakeReq;

  always #4 clk = ~clk;  // 125 MHz

  hib_wake_ctrl dut_i (
    .clk(clk), .rstN(rstN), .hibEnter(hibEnter), .rtcWake(rtcWake),
    .gpioIn(gpioIn), .uartRx(uartRx), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .wakeReq(wakeReq));

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wakeCount = 0;
  int wakeAt = -1;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (wakeReq) begin wakeCount <= wakeCount + 1; wakeAt <= cyc; end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    regAddr = a; #1; v = int'(regRdData);
  endtask

  task automatic enterHib();
    hibEnter = 1'b1; tick(1); hibEnter = 1'b0;
  endtask

  task automatic rtcPulse();
    rtcWake = 1'b1; tick(1); rtcWake = 1'b0;
  endtask

  initial begin
    int v, base, c0;
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    chk(wakeReq == 1'b0, "R1", "wakeReq after reset", wakeReq, 0);
    rd(2'd3, v); chk(v == 0, "R1", "status after reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R1", "trigger cfg after reset", v, 0);

    // R3/R12/R7/R9 sweep over every pin and mode
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 8; p++) begin
        logic idle;
        idle = (m == 0 || m == 2);
        gpioIn = {8{idle}};
        wr(2'd1, {8{m[1:0]}});
        tick(4);
        enterHib();
        rd(2'd3, v); chk(v == 0, "R11", "status cleared on entry", v, 0);
        wr(2'd0, 16'(1 << p));
        rd(2'd0, v); chk(v == 0, "R2", "pin enable readback", v, 0);
        base = wakeCount;
        tick(4);
        chk(wakeCount == base, "R3", "no wake while pin idle", wakeCount - base, 0);
        c0 = cyc;
        gpioIn[p] = ~idle;
        tick(6);
        chk(wakeCount == base + 1 && wakeAt == c0 + 3, "R12", "wake cycle offset",
            wakeAt - c0, 3);
        rd(2'd3, v); chk(v == 9, "R7", "status after pin wake", v, 9);
        if (m < 2) begin
          enterHib();
          base = wakeCount;
          tick(6);
          chk(wakeCount == base, "R9", "pin disarmed after wake", wakeCount - base, 0);
          rtcPulse();
          tick(2);
        end
        gpioIn = {8{idle}};
        tick(4);
      end
    end

    // R4 unarmed pins ignored
    gpioIn = 8'h00;
    wr(2'd1, 16'h5555);
    tick(4);
    enterHib();
    wr(2'd0, 16'h0008);
    base = wakeCount;
    gpioIn = 8'hF7;
    tick(6);
    chk(wakeCount == base, "R4", "unarmed pins ignored", wakeCount - base, 0);
    gpioIn = 8'hFF;
    tick(6);
    chk(wakeCount == base + 1, "R4", "armed pin wakes", wakeCount - base, 1);
    gpioIn = 8'h00;
    tick(4);

    // R5 UART wake, unarmed then armed
    uartRx = 1'b1;
    enterHib();
    base = wakeCount;
    uartRx = 1'b0; tick(6); uartRx = 1'b1; tick(4);
    chk(wakeCount == base, "R5", "unarmed uart ignored", wakeCount - base, 0);
    rtcPulse(); tick(2);
    enterHib();
    wr(2'd2, 16'h0001);
    rd(2'd2, v); chk(v == 0, "R2", "uart enable readback", v, 0);
    tick(4);
    base = wakeCount;
    c0 = cyc;
    uartRx = 1'b0;
    tick(6);
    chk(wakeCount == base + 1 && wakeAt == c0 + 3, "R5", "uart wake cycle offset", wakeAt - c0, 3);
    rd(2'd3, v); chk(v == 3, "R7", "status after uart wake", v, 3);
    uartRx = 1'b1;
    tick(4);

    // R6 RTC wake with nothing armed
    enterHib();
    tick(2);
    base = wakeCount;
    c0 = cyc;
    rtcPulse();
    tick(3);
    chk(wakeCount == base + 1 && wakeAt == c0 + 1, "R6", "rtc wake cycle offset", wakeAt - c0, 1);
    rd(2'd3, v); chk(v == 5, "R7", "status after rtc wake", v, 5);

    // R8 priority: all three in the same cycle
    wr(2'd1, 16'h5555);
    gpioIn = 8'h00; uartRx = 1'b1;
    tick(4);
    enterHib();
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h0001);
    tick(4);
    base = wakeCount;
    c0 = cyc;
    gpioIn[0] = 1'b1; uartRx = 1'b0;
    tick(2);
    rtcPulse();
    tick(4);
    chk(wakeCount == base + 1 && wakeAt == c0 + 3, "R8", "single wake for coincident sources",
        wakeCount - base, 1);
    rd(2'd3, v); chk(v == 5, "R8", "rtc wins", v, 5);
    gpioIn = 8'h00; uartRx = 1'b1;
    tick(4);
    // pins over uart
    enterHib();
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h0001);
    tick(4);
    gpioIn[0] = 1'b1; uartRx = 1'b0;
    tick(6);
    rd(2'd3, v); chk(v == 9, "R8", "pin wins over uart", v, 9);
    gpioIn = 8'h00;
    uartRx = 1'b1;
    tick(4);
    // uart was disarmed by that wake
    enterHib();
    base = wakeCount;
    uartRx = 1'b0;
    tick(6);
    chk(wakeCount == base, "R9", "uart disarmed after wake", wakeCount - base, 0);
    uartRx = 1'b1;
    rtcPulse(); tick(4);

    // R10 awake: activity ignored, arming kept
    rd(2'd3, v); base = v;
    wr(2'd0, 16'h0004);
    c0 = wakeCount;
    gpioIn[2] = 1'b1;
    tick(6);
    chk(wakeCount == c0, "R10", "no wake while awake", wakeCount - c0, 0);
    rd(2'd3, v); chk(v == base, "R11", "status held while awake", v, base);
    enterHib();
    tick(4);
    chk(wakeCount == c0 + 1, "R10", "arming kept across awake time", wakeCount - c0, 1);
    rd(2'd3, v); chk(v == 9, "R10", "status after deferred wake", v, 9);
    gpioIn = 8'h00;
    tick(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule